// File: doc/BRIEF.md
# Terminal-Side Multiframe Tracker and Q-Channel Inserter

This block sits on the terminal end of a basic-rate S/T link, after frame alignment. The frame aligner gives one strobe per received line frame, together with that frame's Fa, N, M and S overhead bits. The far end marks the first frame of every five-frame group by sending Fa=1 with N=0. From these group starts the block acquires lock and keeps it with a flywheel. It uses the M bit to find frame 1 of the twenty-frame multiframe and counts the position inside the multiframe.

Once lock and multiframe alignment are both held, the block drives the outgoing Fa bit. In the frame after each accepted group start it sends one bit of a 4-bit Q nibble; in every other frame it sends 0. It also collects the twenty received S bits into a word ordered by subchannel and pulses a strobe when the word is complete. The latest M and S bits are presented on one serial overhead output, with a flag that tells which of the two is shown.

Top module: `te_mframe_tracker`

## Requirements
- R1: While `rst` is high and after it is released, `locked`, `tx_fa`, `s_valid` and `ovh_is_m` are 0.
- R2: While unlocked, a received frame with Fa=1 and N=0 is a group start. Lock is declared on a group start that comes exactly 5 frames after the previous one. A start at any other spacing restarts the hunt from that frame.
- R3: While locked, the block expects a group start every 5th frame. One expected frame with no start keeps lock. Two expected starts missing in a row clear `locked` at the second one. Starts in other frames are ignored.
- R4: An accepted group start with M=1 sets the multiframe position to 0 (frame 1). After each accepted start while aligned, `tx_fa` becomes `q_nibble[k]`, where k = position div 5. So `q_nibble[0]` is sent first and `q_nibble[3]` last.
- R5: `tx_fa` is 0 after every frame that is not an accepted group start. It is also 0 whenever the block is unlocked or not yet aligned to the multiframe.
- R6: Each received S bit at position p (0..19) goes to `s_word[(p mod 5)*4 + (p div 5)]`. This is subchannel (p mod 5)+1, bit (p div 5)+1. `s_valid` pulses for one cycle, with the new `s_word`, after position 19 of a locked and aligned multiframe.
- R7: In the cycle after a frame strobe, `ovh_is_m`=1 and `ovh_bit` carries that frame's M bit. From the next cycle until the next strobe, `ovh_is_m`=0 and `ovh_bit` carries the S bit.
- R8: `tx_fa` changes only in the cycle after a frame strobe. Between strobes it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_stb | input | 1 | One-cycle pulse per received frame; overhead inputs are valid with it |
| rx_fa | input | 1 | Received Fa bit |
| rx_n | input | 1 | Received N bit |
| rx_m | input | 1 | Received M bit |
| rx_s | input | 1 | Received S bit |
| q_nibble | input | 4 | Q bits to send, bit 0 first |
| tx_fa | output | 1 | Fa bit for the next transmitted frame |
| locked | output | 1 | Group-start lock held |
| mf_pos | output | 5 | Multiframe position 0..19 of the last frame |
| ovh_bit | output | 1 | Serial M/S overhead presentation |
| ovh_is_m | output | 1 | 1 when `ovh_bit` carries the M bit |
| s_word | output | 20 | Collected S subchannel word |
| s_valid | output | 1 | One-cycle pulse when `s_word` is complete |

## Verification
The bench sends a second group start three frames after the first. A design that skips the spacing check would lock there early. Single and double missing starts while locked are both exercised: a design that counts misses wrongly either drops lock after one gap or never drops it. Q bits are checked at each of the four group positions with an uneven nibble, so a reversed or shifted bit order gives wrong values. The first collected S word is compared against the subchannel-major mapping, which catches transposed indexing. The bench also checks that lock taken on a start with M=0 does not insert Q bits before M alignment.

// File: rtl/mf_pkg.sv
package mf_pkg;
    localparam int GRP_LEN = 5;
    localparam int GRP_CNT = 4;
    localparam int MF_LEN  = GRP_LEN * GRP_CNT;
    localparam int POS_W   = $clog2(MF_LEN);
    localparam int GPOS_W  = $clog2(GRP_LEN);
    localparam int GIDX_W  = $clog2(GRP_CNT);

    typedef logic [POS_W-1:0]  pos_t;
    typedef logic [GPOS_W-1:0] gpos_t;
    typedef logic [GIDX_W-1:0] gidx_t;

    typedef struct packed {
        logic fa;
        logic n;
        logic m;
        logic s;
    } rx_ovh_t;

    typedef struct packed {
        logic  locked;
        logic  aligned;
        logic  accept;
        pos_t  pos;
    } frm_info_t;

    function automatic pos_t s_index(input pos_t p);
        int pi;
        pi = int'(p);
        return pos_t'((pi % GRP_LEN) * GRP_CNT + pi / GRP_LEN);
    endfunction

    function automatic gidx_t grp_of(input pos_t p);
        return gidx_t'(int'(p) / GRP_LEN);
    endfunction
endpackage

// File: rtl/mf_tracker.sv
module mf_tracker
    import mf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      stb,
    input  rx_ovh_t   rx,
    output frm_info_t info,
    output logic      locked_o,
    output pos_t      pos_o
);
    logic  locked_q, locked_n;
    logic  cand_q, cand_n;
    logic  miss_q, miss_n;
    logic  aligned_q, aligned_n;
    gpos_t gpos_q, gpos_n;
    pos_t  pos_q, pos_n;
    logic  accept, start, gpos_last;
    gpos_t gpos_inc;

    always_comb begin
        locked_n  = locked_q;
        cand_n    = cand_q;
        miss_n    = miss_q;
        aligned_n = aligned_q;
        gpos_n    = gpos_q;
        accept    = 1'b0;
        start     = rx.fa & ~rx.n;
        gpos_last = (gpos_q == gpos_t'(GRP_LEN - 1));
        gpos_inc  = gpos_last ? '0 : gpos_q + 1'b1;

        if (!locked_q) begin
            if (start) begin
                if (cand_q && gpos_last) begin
                    locked_n = 1'b1;
                    accept   = 1'b1;
                    miss_n   = 1'b0;
                end
                cand_n = 1'b1;
                gpos_n = '0;
            end else if (cand_q) begin
                if (gpos_last) cand_n = 1'b0;
                else           gpos_n = gpos_inc;
            end
        end else begin
            gpos_n = gpos_inc;
            if (gpos_last) begin
                if (start) begin
                    accept = 1'b1;
                    miss_n = 1'b0;
                end else if (miss_q) begin
                    locked_n = 1'b0;
                    cand_n   = 1'b0;
                end else begin
                    miss_n = 1'b1;
                end
            end
        end

        pos_n = (pos_q == pos_t'(MF_LEN - 1)) ? '0 : pos_q + 1'b1;
        if (accept && rx.m) begin
            pos_n     = '0;
            aligned_n = 1'b1;
        end
        if (!locked_n) aligned_n = 1'b0;

        info = '{locked: locked_n, aligned: aligned_n, accept: accept, pos: pos_n};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            locked_q  <= 1'b0;
            cand_q    <= 1'b0;
            miss_q    <= 1'b0;
            aligned_q <= 1'b0;
            gpos_q    <= '0;
            pos_q     <= '0;
        end else if (stb) begin
            locked_q  <= locked_n;
            cand_q    <= cand_n;
            miss_q    <= miss_n;
            aligned_q <= aligned_n;
            gpos_q    <= gpos_n;
            pos_q     <= pos_n;
        end
    end

    assign locked_o = locked_q;
    assign pos_o    = pos_q;

    // R2
    lock_on_frame_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(locked_q) |-> $past(stb));

    // R3
    drop_on_frame_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(locked_q) |-> $past(stb));

    // R4
    pos_range_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(pos_q) < MF_LEN) && (int'(gpos_q) < GRP_LEN));
endmodule

// File: rtl/s_collector.sv
module s_collector
    import mf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        stb,
    input  frm_info_t   info,
    input  logic        rx_m,
    input  logic        rx_s,
    output logic [MF_LEN-1:0] word_o,
    output logic        valid_o,
    output logic        ovh_bit_o,
    output logic        ovh_is_m_o
);
    logic [MF_LEN-1:0] shadow_q, shadow_n;
    logic              cap, last;
    logic              m_q, s_q, phase_q;

    always_comb begin
        cap      = stb && info.locked && info.aligned;
        last     = (info.pos == pos_t'(MF_LEN - 1));
        shadow_n = shadow_q;
        if (cap) shadow_n[s_index(info.pos)] = rx_s;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            word_o   <= '0;
            valid_o  <= 1'b0;
            m_q      <= 1'b0;
            s_q      <= 1'b0;
            phase_q  <= 1'b0;
        end else begin
            valid_o <= cap && last;
            phase_q <= stb;
            if (cap) shadow_q <= shadow_n;
            if (cap && last) word_o <= shadow_n;
            if (stb) begin
                m_q <= rx_m;
                s_q <= rx_s;
            end
        end
    end

    assign ovh_is_m_o = phase_q;
    assign ovh_bit_o  = phase_q ? m_q : s_q;

    // R7
    m_phase_chk: assert property (@(posedge clk) disable iff (rst)
        ovh_is_m_o |=> !ovh_is_m_o || $past(stb));

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);
endmodule

// File: rtl/q_inserter.sv
module q_inserter
    import mf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  frm_info_t         info,
    input  logic [GRP_CNT-1:0] q_bits,
    output logic              tx_fa_o
);
    logic ins;

    always_comb ins = info.accept && info.locked && info.aligned;

    always_ff @(posedge clk) begin
        if (rst)      tx_fa_o <= 1'b0;
        else if (stb) tx_fa_o <= ins ? q_bits[grp_of(info.pos)] : 1'b0;
    end

    // R8
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !stb |=> $stable(tx_fa_o));
endmodule

// File: rtl/te_mframe_tracker.sv
module te_mframe_tracker
    import mf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        frame_stb,
    input  logic        rx_fa,
    input  logic        rx_n,
    input  logic        rx_m,
    input  logic        rx_s,
    input  logic [3:0]  q_nibble,
    output logic        tx_fa,
    output logic        locked,
    output logic [4:0]  mf_pos,
    output logic        ovh_bit,
    output logic        ovh_is_m,
    output logic [19:0] s_word,
    output logic        s_valid
);
    rx_ovh_t   rx;
    frm_info_t info;

    assign rx = '{fa: rx_fa, n: rx_n, m: rx_m, s: rx_s};

    mf_tracker u_trk (
        .clk(clk), .rst(rst), .stb(frame_stb), .rx(rx),
        .info(info), .locked_o(locked), .pos_o(mf_pos)
    );

    s_collector u_scol (
        .clk(clk), .rst(rst), .stb(frame_stb), .info(info),
        .rx_m(rx_m), .rx_s(rx_s), .word_o(s_word), .valid_o(s_valid),
        .ovh_bit_o(ovh_bit), .ovh_is_m_o(ovh_is_m)
    );

    q_inserter u_qins (
        .clk(clk), .rst(rst), .stb(frame_stb), .info(info),
        .q_bits(q_nibble), .tx_fa_o(tx_fa)
    );

    // R5
    tx_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
        tx_fa |-> locked);

    // R6
    word_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
        s_valid |-> locked);
endmodule

// File: tb/te_mframe_tracker_tb.sv
`timescale 1ns/1ps
module te_mframe_tracker_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_stb = 1'b0;
    logic        rx_fa = 1'b0, rx_n = 1'b1, rx_m = 1'b0, rx_s = 1'b0;
    logic [3:0]  q_nibble = 4'b1011;
    logic        tx_fa, locked, ovh_bit, ovh_is_m, s_valid;
    logic [4:0]  mf_pos;
    logic [19:0] s_word;

    int n_chk = 0;
    int n_fail = 0;
    int n_valid = 0;
    logic [19:0] first_word = '0;
    logic [19:0] exp_word;
    bit done = 0;

    always #2 clk = ~clk;

    te_mframe_tracker u_dut (
        .clk(clk), .rst(rst), .frame_stb(frame_stb), .rx_fa(rx_fa), .rx_n(rx_n),
        .rx_m(rx_m), .rx_s(rx_s), .q_nibble(q_nibble), .tx_fa(tx_fa),
        .locked(locked), .mf_pos(mf_pos), .ovh_bit(ovh_bit), .ovh_is_m(ovh_is_m),
        .s_word(s_word), .s_valid(s_valid)
    );

    always @(negedge clk) begin
        if (s_valid) begin
            if (n_valid == 0) first_word = s_word;
            n_valid++;
        end
    end

    // Group rows: {start, m, s5[4:0], exp_lock, exp_tx}; s5[0] goes in the start frame
    localparam logic [8:0] GRP_TBL [0:14] = '{
        {1'b1, 1'b1, 5'b00000, 1'b0, 1'b0},
        {1'b1, 1'b0, 5'b00000, 1'b1, 1'b0},
        {1'b1, 1'b0, 5'b00000, 1'b1, 1'b0},
        {1'b1, 1'b0, 5'b00000, 1'b1, 1'b0},
        {1'b1, 1'b1, 5'b10110, 1'b1, 1'b1},
        {1'b1, 1'b0, 5'b01101, 1'b1, 1'b1},
        {1'b1, 1'b0, 5'b11001, 1'b1, 1'b0},
        {1'b1, 1'b0, 5'b00111, 1'b1, 1'b1},
        {1'b1, 1'b1, 5'b00000, 1'b1, 1'b1},
        {1'b0, 1'b0, 5'b00000, 1'b1, 1'b0},
        {1'b1, 1'b0, 5'b00000, 1'b1, 1'b0},
        {1'b0, 1'b0, 5'b00000, 1'b1, 1'b0},
        {1'b0, 1'b0, 5'b00000, 1'b0, 1'b0},
        {1'b1, 1'b1, 5'b00000, 1'b0, 1'b0},
        {1'b1, 1'b0, 5'b00000, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic [19:0] act, input logic [19:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(input logic fa, input logic n, input logic m, input logic s);
        @(negedge clk);
        frame_stb = 1'b1; rx_fa = fa; rx_n = n; rx_m = m; rx_s = s;
        @(negedge clk);
        frame_stb = 1'b0;
    endtask

    task automatic idle(input int c);
        repeat (c) @(negedge clk);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        // R1: state while reset is held
        chk("R1 locked in reset", {19'b0, locked}, 20'd0);
        chk("R1 tx_fa in reset", {19'b0, tx_fa}, 20'd0);
        rst = 1'b0;
        idle(2);
        chk("R1 s_valid after reset", {19'b0, s_valid}, 20'd0);
        chk("R1 ovh_is_m after reset", {19'b0, ovh_is_m}, 20'd0);

        for (int r = 0; r < 15; r++) begin
            logic [8:0] row;
            row = GRP_TBL[r];
            send(row[8], ~row[8], row[7], row[2]);
            chk($sformatf("R2 R3 lock after group %0d start", r), {19'b0, locked}, {19'b0, row[1]});
            chk($sformatf("R4 R5 tx_fa after group %0d start", r), {19'b0, tx_fa}, {19'b0, row[0]});
            idle(2);
            chk($sformatf("R8 tx_fa held in group %0d", r), {19'b0, tx_fa}, {19'b0, row[0]});
            for (int j = 1; j < 5; j++) begin
                send(1'b0, 1'b1, 1'b0, row[2 + j]);
                chk($sformatf("R5 tx_fa zero group %0d frame %0d", r, j), {19'b0, tx_fa}, 20'd0);
                chk($sformatf("R3 lock group %0d frame %0d", r, j), {19'b0, locked}, {19'b0, row[1]});
                idle(1);
            end
        end

        // R6: expected S word from rows 4..7 using index (p mod 5)*4 + p div 5
        exp_word = '0;
        for (int g = 0; g < 4; g++) begin
            for (int j = 0; j < 5; j++) begin
                exp_word[j * 4 + g] = GRP_TBL[4 + g][2 + j];
            end
        end
        chk("R6 s_valid pulse count", 20'(n_valid), 20'd2);
        chk("R6 collected S word", first_word, exp_word);

        // R2: misplaced second start must not lock
        rst = 1'b1; idle(2); rst = 1'b0; idle(1);
        send(1'b1, 1'b0, 1'b0, 1'b0);
        send(1'b0, 1'b1, 1'b0, 1'b0);
        send(1'b0, 1'b1, 1'b0, 1'b0);
        send(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R2 no lock at 3-frame spacing", {19'b0, locked}, 20'd0);
        for (int j = 0; j < 4; j++) send(1'b0, 1'b1, 1'b0, 1'b0);
        chk("R2 still unlocked before spacing", {19'b0, locked}, 20'd0);
        send(1'b1, 1'b0, 1'b1, 1'b0);
        chk("R2 lock at 5-frame spacing", {19'b0, locked}, 20'd1);
        chk("R4 first Q bit after lock with M=1", {19'b0, tx_fa}, 20'd1);

        // R7: M shown first, then S
        send(1'b0, 1'b1, 1'b1, 1'b0);
        chk("R7 ovh_is_m after strobe", {19'b0, ovh_is_m}, 20'd1);
        chk("R7 ovh_bit carries M", {19'b0, ovh_bit}, 20'd1);
        idle(1);
        chk("R7 ovh_is_m cleared", {19'b0, ovh_is_m}, 20'd0);
        chk("R7 ovh_bit carries S", {19'b0, ovh_bit}, 20'd0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule